// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This unit makes the hazard decisions for an in-order integer pipeline whose stages are fetch, register read with decode, execute, memory access and write-back. Every cycle the datapath gives it the decoded fields of the instruction in the read stage. These are the two source register numbers with their use flags, the destination number, the write-enable and load flags, a branch flag and the branch comparator's outcome. The unit keeps its own short record of the instructions that have moved on into execute and memory. From that record it decides whether to freeze fetch and read, whether to send a no-op into execute, which bypass path each execute operand takes, which value the read-stage branch comparator uses, and whether fetch is redirected.

Branches are resolved in the read stage and have one architectural delay slot. The instruction fetched after a branch is never killed. It enters read and then execute like any other instruction. A load followed by a dependent instruction costs one interlocked cycle. Any other result one or two instructions ahead is bypassed. A branch that needs a value still being computed is held in the read stage until the value can be compared.

Top module: `hz_ctrl`

## Requirements
- R1: When the instruction ahead (now in execute) writes a nonzero register that a used source of the read-stage instruction names, the execute operand select for that source reads 01 (take the execute/memory result) in the cycle after the read-stage instruction is issued.
- R2: When the match is with the instruction two ahead (now in memory), including a load, the select reads 10 (take the memory/write-back result). With no match it reads 00 (register file).
- R3: Each source chooses on its own. When both older instructions write the same register, the nearer one wins (01 over 10).
- R4: A non-branch instruction that uses the destination of a load in execute raises stall and bubble for exactly one cycle. The cycle after a stall both execute selects read 00.
- R5: Register 0 is never a hazard. A source naming register 0 gets select 00, and a load to register 0 causes no stall.
- R6: Instructions with write-enable low (stores, branches, bubbles) and slots with the valid flag low never cause forwarding or a stall. An invalid read-stage slot never stalls.
- R7: A branch whose source is written by a non-load in execute is held one cycle. It then proceeds with the branch compare select for that source at 1 (memory-stage result).
- R8: A branch whose source is written by a load in execute is held two cycles. It then proceeds with branch compare selects at 0 (register file).
- R9: redirect is high only for a valid branch in read whose condition is true and which is not held. The next instruction (the delay slot) then enters execute without a bubble.
- R10: Synchronous active-high reset clears the record of older instructions. Afterwards all selects read 00 and no instruction issued before the reset causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read stage holds a real instruction |
| rd_src1 | input | REG_W | First source register number |
| rd_src2 | input | REG_W | Second source register number |
| rd_use1 | input | 1 | First source is read |
| rd_use2 | input | 1 | Second source is read |
| rd_dst | input | REG_W | Destination register number |
| rd_wen | input | 1 | Instruction writes its destination |
| rd_load | input | 1 | Instruction is a load |
| rd_branch | input | 1 | Instruction is a conditional branch |
| rd_cond | input | 1 | Branch comparator says taken |
| stall | output | 1 | Hold PC and the fetch/read register |
| bubble | output | 1 | Put a no-op into execute |
| fwd_a | output | 2 | Execute operand A select: 00 file, 01 exe/mem, 10 mem/wb |
| fwd_b | output | 2 | Execute operand B select, same code |
| brfwd_a | output | 1 | Branch compare A takes the memory-stage result |
| brfwd_b | output | 1 | Branch compare B takes the memory-stage result |
| redirect | output | 1 | Load the branch target into the PC |

## Verification
A single instruction stream is run through the controller. It mixes producers at distance one and two, a consumer whose operands come from different stages, and two producers writing the same register. Stores, register 0 and invalid slots are placed where a match on register number alone would wrongly forward. A load followed by its consumer separates the interlocked case from plain bypassing. Branches fed by an ALU result and by a load separate the one-cycle hold from the two-cycle hold, and the instruction after a taken branch confirms that the delay slot is not squashed. A reset applied between a load and its consumer shows that the record of older instructions is cleared.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned HZ_REG_W = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EXM = 2'b01,
    FWD_MWB = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic                vld;
    logic [HZ_REG_W-1:0] dst;
    logic                wen;
    logic                load;
  } stage_tag_t;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] src,
  input  logic         use_i,
  input  logic         vld,
  input  logic         wen,
  input  logic [W-1:0] dst,
  output logic         hit
);
  // a producer only counts when it really writes a nonzero register
  always_comb hit = use_i & vld & wen & (dst != '0) & (src == dst);
endmodule

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  stage_tag_t rd_tag,
  output stage_tag_t ex_tag,
  output stage_tag_t mem_tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_tag  <= '0;
      mem_tag <= '0;
    end else begin
      mem_tag <= ex_tag;
      ex_tag  <= issue ? rd_tag : '0;  // empty tag models the bubble
    end
  end
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  input  logic     hit_ex,
  input  logic     hit_mem,
  output fwd_sel_e sel
);
  // select is computed one stage early and registered with the instruction
  always_ff @(posedge clk) begin
    if (rst || !adv) sel <= FWD_RF;
    else if (hit_ex)  sel <= FWD_EXM;
    else if (hit_mem) sel <= FWD_MWB;
    else              sel <= FWD_RF;
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = HZ_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic [REG_W-1:0] rd_src1,
  input  logic [REG_W-1:0] rd_src2,
  input  logic             rd_use1,
  input  logic             rd_use2,
  input  logic [REG_W-1:0] rd_dst,
  input  logic             rd_wen,
  input  logic             rd_load,
  input  logic             rd_branch,
  input  logic             rd_cond,
  output logic             stall,
  output logic             bubble,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             brfwd_a,
  output logic             brfwd_b,
  output logic             redirect
);
  localparam int unsigned N_SRC = 2;

  stage_tag_t             rd_tag, ex_tag, mem_tag;
  logic [REG_W-1:0]       src   [N_SRC];
  logic [N_SRC-1:0]       use_v;
  logic [N_SRC-1:0]       hit_ex, hit_mem, brsel;
  fwd_sel_e               sel   [N_SRC];
  logic                   ld_hit, br_hold, issue;

  always_comb begin
    rd_tag.vld  = rd_valid;
    rd_tag.dst  = rd_dst;
    rd_tag.wen  = rd_wen;
    rd_tag.load = rd_load;
    src[0] = rd_src1;
    src[1] = rd_src2;
    use_v  = {rd_use2, rd_use1};
  end

  hz_tag_pipe u_tags (
    .clk(clk), .rst(rst), .issue(issue), .rd_tag(rd_tag),
    .ex_tag(ex_tag), .mem_tag(mem_tag)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    hz_match #(.W(REG_W)) u_mex (
      .src(src[k]), .use_i(use_v[k]), .vld(ex_tag.vld), .wen(ex_tag.wen),
      .dst(ex_tag.dst), .hit(hit_ex[k])
    );
    hz_match #(.W(REG_W)) u_mmem (
      .src(src[k]), .use_i(use_v[k]), .vld(mem_tag.vld), .wen(mem_tag.wen),
      .dst(mem_tag.dst), .hit(hit_mem[k])
    );
    hz_fwd_reg u_sel (
      .clk(clk), .rst(rst), .adv(issue), .hit_ex(hit_ex[k]),
      .hit_mem(hit_mem[k]), .sel(sel[k])
    );
    // branch comparator may bypass a finished ALU result from memory stage
    always_comb brsel[k] = rd_valid & rd_branch & hit_mem[k] & ~mem_tag.load;
  end

  always_comb begin
    ld_hit  = ex_tag.load & (|hit_ex);
    br_hold = (|hit_ex) | (mem_tag.load & (|hit_mem));
    stall   = rd_valid & (rd_branch ? br_hold : ld_hit);
    issue   = rd_valid & ~stall;
    bubble  = stall;
    // no flush: the delay-slot instruction in fetch always continues
    redirect = rd_valid & rd_branch & rd_cond & ~stall;
    fwd_a   = sel[0];
    fwd_b   = sel[1];
    brfwd_a = brsel[0];
    brfwd_b = brsel[1];
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_valid,
  input logic [REG_W-1:0] rd_src1,
  input logic [REG_W-1:0] rd_src2,
  input logic             rd_branch,
  input logic             rd_cond,
  input logic             stall,
  input logic             bubble,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             brfwd_a,
  input logic             brfwd_b,
  input logic             redirect
);
  logic [1:0] armed_cnt;
  logic       armed;
  always_ff @(posedge clk) begin
    if (rst) armed_cnt <= '0;
    else if (armed_cnt != 2'd2) armed_cnt <= armed_cnt + 2'd1;
  end
  assign armed = (armed_cnt == 2'd2);

  p_bubble_clears_sel_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    stall |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  p_load_stall_once_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_valid && stall && !rd_branch) |=>
      (!stall || !$stable(rd_src1) || !$stable(rd_src2) || !$stable(rd_branch)));

  p_branch_hold_max_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_valid && rd_branch && stall && $past(stall)) |=>
      (!stall || !$stable(rd_src1) || !$stable(rd_src2) || !$stable(rd_branch)));

  p_zero_src_a_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_src1 == '0) |=> (fwd_a == 2'b00));

  p_zero_src_b_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_src2 == '0) |=> (fwd_b == 2'b00));

  p_sel_code_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  p_redirect_taken_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    redirect |-> (rd_valid && rd_branch && rd_cond && !bubble));

  p_brfwd_branch_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    (brfwd_a || brfwd_b) |-> (rd_valid && rd_branch));
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W)) i_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_src1(rd_src1),
  .rd_src2(rd_src2), .rd_branch(rd_branch), .rd_cond(rd_cond),
  .stall(stall), .bubble(bubble), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .brfwd_a(brfwd_a), .brfwd_b(brfwd_b), .redirect(redirect)
);

// File: tb/test_hz_ctrl.sv
module test_hz_ctrl;
  localparam int W = 5;
  localparam int NV = 26;

  typedef struct packed {
    logic v; logic [4:0] s1; logic [4:0] s2; logic u1; logic u2;
    logic [4:0] d; logic w; logic l; logic b; logic c;
    logic xs; logic xr; logic xba; logic xbb; logic [1:0] xfa; logic [1:0] xfb;
  } vec_t;

  // fields: v s1 s2 u1 u2 d w l b c | stall redir bfa bfb fa fb
  localparam vec_t TBL [NV] = '{
    '{1, 2, 3,1,1, 1,1,0,0,0, 0,0,0,0,0,0},  // add r1: no producers
    '{1, 1, 5,1,1, 4,1,0,0,0, 0,0,0,0,1,0},  // R1 r1 from exe
    '{1, 5, 1,1,1, 6,1,0,0,0, 0,0,0,0,0,2},  // R2 r1 from mem
    '{1, 6, 4,1,1, 7,1,0,0,0, 0,0,0,0,1,2},  // R3 operands differ
    '{1, 7, 7,1,1, 8,1,0,0,0, 0,0,0,0,1,1},  // R1 both
    '{1, 8, 0,1,0, 9,1,1,0,0, 0,0,0,0,1,0},  // lw r9
    '{1, 9, 0,1,1,10,1,0,0,0, 1,0,0,0,0,0},  // R4 load-use stall
    '{1, 9, 0,1,1,10,1,0,0,0, 0,0,0,0,2,0},  // R4 released, R2 load via mem
    '{1,10,10,1,1, 0,1,0,0,0, 0,0,0,0,1,1},  // writes r0
    '{1, 0, 0,1,1,11,1,0,0,0, 0,0,0,0,0,0},  // R5 r0 sources
    '{1,11, 0,1,0, 0,1,1,0,0, 0,0,0,0,1,0},  // lw r0
    '{1, 0, 0,1,1,12,1,0,0,0, 0,0,0,0,0,0},  // R5 no stall on r0 load
    '{1,12,11,1,1, 0,0,0,1,1, 1,0,0,0,0,0},  // R7 branch held
    '{1,12,11,1,1, 0,0,0,1,1, 0,1,1,0,2,0},  // R7 go, R9 redirect
    '{1,12, 2,1,1,13,1,0,0,0, 0,0,0,0,0,0},  // R9 delay slot issues
    '{1,13, 0,1,0,14,1,1,0,0, 0,0,0,0,1,0},  // lw r14
    '{1,14,13,1,1, 0,0,0,1,1, 1,0,0,1,0,0},  // R8 hold 1
    '{1,14,13,1,1, 0,0,0,1,1, 1,0,0,0,0,0},  // R8 hold 2
    '{1,14,13,1,1, 0,0,0,1,1, 0,1,0,0,0,0},  // R8 go, R9 redirect
    '{1, 1, 2,1,1,15,1,0,0,0, 0,0,0,0,0,0},  // R9 delay slot
    '{1, 3, 4,1,1, 0,0,0,1,0, 0,0,0,0,0,0},  // R9 not taken
    '{0,15, 0,1,0, 0,0,0,1,1, 0,0,0,0,0,0},  // R6 invalid slot
    '{1, 1, 2,1,1, 1,0,0,0,0, 0,0,0,0,0,0},  // store, dst field 1
    '{1, 1, 1,1,1,17,1,0,0,0, 0,0,0,0,0,0},  // R6 store never forwards
    '{1, 5, 6,1,1,17,1,0,0,0, 0,0,0,0,0,0},  // add r17 again
    '{1,17,17,1,1,18,1,0,0,0, 0,0,0,0,1,1}   // R3 nearer wins
  };

  logic clk = 1'b0, rst = 1'b1;
  logic rd_valid, rd_use1, rd_use2, rd_wen, rd_load, rd_branch, rd_cond;
  logic [W-1:0] rd_src1, rd_src2, rd_dst;
  logic stall, bubble, brfwd_a, brfwd_b, redirect;
  logic [1:0] fwd_a, fwd_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hz_ctrl #(.REG_W(W)) i_hz_ctrl (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_src1(rd_src1),
    .rd_src2(rd_src2), .rd_use1(rd_use1), .rd_use2(rd_use2),
    .rd_dst(rd_dst), .rd_wen(rd_wen), .rd_load(rd_load),
    .rd_branch(rd_branch), .rd_cond(rd_cond), .stall(stall),
    .bubble(bubble), .fwd_a(fwd_a), .fwd_b(fwd_b), .brfwd_a(brfwd_a),
    .brfwd_b(brfwd_b), .redirect(redirect)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t x);
    rd_valid = x.v; rd_src1 = x.s1; rd_src2 = x.s2; rd_use1 = x.u1;
    rd_use2 = x.u2; rd_dst = x.d; rd_wen = x.w; rd_load = x.l;
    rd_branch = x.b; rd_cond = x.c;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    drive('0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 stall after reset", stall, 0);
    chk("R10 redirect after reset", redirect, 0);
    chk("R10 fwd_a after reset", fwd_a, 0);
    chk("R10 fwd_b after reset", fwd_b, 0);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) begin
        @(negedge clk);
        chk($sformatf("vec%0d fwd_a (R1 R2 R3 R4 R5 R6)", i-1), fwd_a, TBL[i-1].xfa);
        chk($sformatf("vec%0d fwd_b (R1 R2 R3 R4 R5 R6)", i-1), fwd_b, TBL[i-1].xfb);
      end
      drive(TBL[i]);
      #2;
      chk($sformatf("vec%0d stall (R4 R7 R8)", i), stall, TBL[i].xs);
      chk($sformatf("vec%0d bubble (R4 R9)", i), bubble, TBL[i].xs);
      chk($sformatf("vec%0d redirect (R9)", i), redirect, TBL[i].xr);
      chk($sformatf("vec%0d brfwd_a (R7 R8)", i), brfwd_a, TBL[i].xba);
      chk($sformatf("vec%0d brfwd_b (R7 R8)", i), brfwd_b, TBL[i].xbb);
    end
    @(negedge clk);
    chk("last fwd_a R3", fwd_a, TBL[NV-1].xfa);
    chk("last fwd_b R3", fwd_b, TBL[NV-1].xfb);

    // R10: load r9, reset, then a consumer of r9 must not stall
    drive('{1, 1, 0,1,0, 9,1,1,0,0, 0,0,0,0,0,0});
    @(negedge clk);
    rst = 1'b1;
    drive('0);
    @(negedge clk);
    rst = 1'b0;
    drive('{1, 9, 9,1,1, 3,1,0,0,0, 0,0,0,0,0,0});
    #2;
    chk("R10 no stall from pre-reset load", stall, 0);
    @(negedge clk);
    chk("R10 fwd_a cleared by reset", fwd_a, 0);
    chk("R10 fwd_b cleared by reset", fwd_b, 0);

    done = 1;
    finish_run();
  end
endmodule